// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an interrupt router. A processor reaches it through two 32-bit locations: a select register holding an 8-bit register number, and a data window through which the selected register is read or written. Behind the window sit an 8-bit controller identifier, a read-only version word and a table of redirection entries, each 64 bits wide. Each entry is split across two consecutive register numbers, one for each 32-bit half.

The entire table is exported as a flat vector to the interrupt service logic. A one-cycle update strobe tells that logic to rescan pending interrupts whenever software changes any entry. The bus side uses single-cycle read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `redir_reg_window`

## Requirements
- R1: Only offsets 0x00 (select) and 0x10 (data window) are decoded. A read at any other offset returns zero, and a write there changes no state and raises no update strobe.
- R2: A write to offset 0x00 loads the select register from write bits 7:0. A read of offset 0x00 returns the select value in bits 7:0, with bits 31:8 zero.
- R3: With select 0x00, a window write loads the identifier from bits 31:24. A window read returns the identifier in bits 31:24, with all other bits zero.
- R4: With select 0x01, a window read returns 0x11 in bits 7:0 and the highest entry number (entry count minus one) in bits 23:16, with other bits zero. Window writes at select 0x01 are ignored.
- R5: Select 0x02 and selects 0x03 to 0x0F read as zero through the window, and window writes at those selects are ignored.
- R6: For a select of 0x10 or above, the entry number is (select − 0x10) / 2. An odd select reaches bits 63:32 of that entry and an even select reaches bits 31:0. A write leaves the other half unchanged.
- R7: A select whose entry number is at or beyond the entry count reads as zero, and window writes at that select change no entry and raise no update strobe.
- R8: After reset, the select register and identifier are zero and every entry holds 0x0000_0000_0001_0000, so only the mask bit (bit 16) is set.
- R9: Every window write that reaches a valid entry raises `tableUpdated` for exactly one cycle, in the cycle after the write strobe. No other access raises it.
- R10: `rdData` is registered. It reflects the state before any write in the same cycle, appears in the cycle after `rdEn`, and holds its value while `rdEn` is low.
- R11: Entry k occupies bits 64k+63 to 64k of `tableFlat`, and a write is visible there in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte offset within the window (low address bits) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| tableFlat | output | NUM_ENTRIES*64 | All redirection entries, entry 0 in the low bits |
| tableUpdated | output | 1 | One-cycle pulse after a valid entry write |

## Verification
The bench builds the block with the default entry count of 24, so the version word carries 23 in bits 23:16. The last entry is reached at selects 0x3E and 0x3F, and select 0x40 is the first out-of-range value. With 24 entries, both sides of the range boundary can be tested. The full 8-bit select range, up to 0xFF, also stays meaningful as out-of-range traffic.

// File: rtl/redir_win_pkg.sv
package redir_win_pkg;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_TBL = 8'h10;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SEL,
    RD_ID,
    RD_VER,
    RD_ENT_LO,
    RD_ENT_HI
  } rdSrc_e;

  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       entWrLo;
    logic       entWrHi;
    logic [6:0] entIdx;
    logic       rdEn;
    rdSrc_e     rdSrc;
  } winStb_t;

endpackage

// File: rtl/redir_win_ctrl.sv
module redir_win_ctrl
  import redir_win_pkg::*;
#(
  parameter int NUM_ENTRIES = 24
) (
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] addr,
  input  logic [7:0] selQ,
  output winStb_t    stb
);

  localparam logic [6:0] ENT_LIMIT = 7'(NUM_ENTRIES);

  logic       isSel;
  logic       isWin;
  logic [6:0] idxFull;
  logic       entValid;

  always_comb begin
    isSel    = (addr == OFF_SEL);
    isWin    = (addr == OFF_WIN);
    // Entry number: (select - 0x10) >> 1, computed on bits 7:1.
    idxFull  = selQ[7:1] - 7'd8;
    entValid = (selQ >= SEL_TBL) && (idxFull < ENT_LIMIT);
  end

  always_comb begin
    stb        = '0;
    stb.rdEn   = rdEn;
    stb.entIdx = idxFull;
    stb.rdSrc  = RD_ZERO;

    if (wrEn) begin
      if (isSel) begin
        stb.selWr = 1'b1;
      end else if (isWin) begin
        if (selQ == SEL_ID) begin
          stb.idWr = 1'b1;
        end else if (entValid) begin
          stb.entWrHi = selQ[0];
          stb.entWrLo = ~selQ[0];
        end
      end
    end

    if (isSel) begin
      stb.rdSrc = RD_SEL;
    end else if (isWin) begin
      if (selQ == SEL_ID) begin
        stb.rdSrc = RD_ID;
      end else if (selQ == SEL_VER) begin
        stb.rdSrc = RD_VER;
      end else if (entValid) begin
        stb.rdSrc = selQ[0] ? RD_ENT_HI : RD_ENT_LO;
      end
    end
  end

endmodule

// File: rtl/redir_win_datapath.sv
module redir_win_datapath
  import redir_win_pkg::*;
#(
  parameter int         NUM_ENTRIES = 24,
  parameter logic [7:0] VERSION     = 8'h11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  winStb_t                   stb,
  input  logic [31:0]               wrData,
  output logic [7:0]                selQ,
  output logic [31:0]               rdData,
  output logic [NUM_ENTRIES*64-1:0] tableFlat,
  output logic                      tableUpdated
);

  localparam logic [7:0]  TOP_ENTRY = 8'(NUM_ENTRIES - 1);
  localparam logic [31:0] VER_WORD  = {8'h00, TOP_ENTRY, 8'h00, VERSION};

  logic [7:0]  idQ;
  logic [63:0] entSel;
  logic [31:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      idQ  <= '0;
    end else begin
      if (stb.selWr) selQ <= wrData[7:0];
      if (stb.idWr)  idQ  <= wrData[31:24];
    end
  end

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_entry
    logic [63:0] entR;
    logic        hit;

    assign hit = (stb.entIdx == 7'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entR <= ENTRY_RST;
      end else if (hit) begin
        if (stb.entWrLo) entR[31:0]  <= wrData;
        if (stb.entWrHi) entR[63:32] <= wrData;
      end
    end

    assign tableFlat[k*64 +: 64] = entR;
  end

  always_comb begin
    entSel = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (stb.entIdx == 7'(k)) entSel = tableFlat[k*64 +: 64];
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      RD_SEL:    rdNext = {24'h0, selQ};
      RD_ID:     rdNext = {idQ, 24'h0};
      RD_VER:    rdNext = VER_WORD;
      RD_ENT_LO: rdNext = entSel[31:0];
      RD_ENT_HI: rdNext = entSel[63:32];
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData       <= '0;
      tableUpdated <= 1'b0;
    end else begin
      if (stb.rdEn) rdData <= rdNext;
      tableUpdated <= stb.entWrLo | stb.entWrHi;
    end
  end

endmodule

// File: rtl/redir_reg_window.sv
module redir_reg_window
  import redir_win_pkg::*;
#(
  parameter int         NUM_ENTRIES = 24,
  parameter logic [7:0] VERSION     = 8'h11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [7:0]                addr,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  output logic [NUM_ENTRIES*64-1:0] tableFlat,
  output logic                      tableUpdated
);

  winStb_t    stb;
  logic [7:0] selQ;

  redir_win_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .selQ (selQ),
    .stb  (stb)
  );

  redir_win_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .VERSION(VERSION)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .selQ         (selQ),
    .rdData       (rdData),
    .tableFlat    (tableFlat),
    .tableUpdated (tableUpdated)
  );

endmodule

// File: rtl/redir_reg_window_chk.sv
module redir_reg_window_chk #(
  parameter int         NUM_ENTRIES = 24,
  parameter logic [7:0] VERSION     = 8'h11
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic                      rdEn,
  input logic [7:0]                addr,
  input logic [31:0]               wrData,
  input logic [31:0]               rdData,
  input logic [NUM_ENTRIES*64-1:0] tableFlat,
  input logic                      tableUpdated,
  input logic [7:0]                selQ
);

  localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

  AST_OFFSET_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr != 8'h00 && addr != 8'h10) |=> (rdData == 32'h0)); // R1

  AST_OFFSET_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != 8'h10) |=> !tableUpdated); // R1

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h00) |=> (selQ == $past(wrData[7:0]))); // R2

  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h10 && selQ == 8'h01) |=> (rdData == VER_EXP)); // R4

  AST_LOW_SEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h10 && selQ < 8'h10) |=> !tableUpdated); // R5

  AST_ENTRY0_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h10 && selQ == 8'h10) |=> (tableFlat[31:0] == $past(wrData))); // R6

  AST_ENTRY0_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h10 && selQ == 8'h11) |=> $stable(tableFlat[31:0])); // R6

  AST_UPDATE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    tableUpdated |-> $past(wrEn && addr == 8'h10 && selQ >= 8'h10)); // R9

  AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (tableUpdated && !$past(wrEn)) |=> !tableUpdated); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R10

endmodule

bind redir_reg_window redir_reg_window_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .VERSION    (VERSION)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .rdEn         (rdEn),
  .addr         (addr),
  .wrData       (wrData),
  .rdData       (rdData),
  .tableFlat    (tableFlat),
  .tableUpdated (tableUpdated),
  .selQ         (selQ)
);

// File: tb/redir_reg_window_bench.sv
`timescale 1ns/1ps
module redir_reg_window_bench;

  localparam int N = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic            rdEn = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic [N*64-1:0] tableFlat;
  logic            tableUpdated;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  redir_reg_window #(.NUM_ENTRIES(N)) u_redir_reg_window (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .tableFlat    (tableFlat),
    .tableUpdated (tableUpdated)
  );

  function automatic logic [63:0] ent(int k);
    return tableFlat[k*64 +: 64];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] a, logic [31:0] d, output logic upd);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    upd = tableUpdated;
  endtask

  task automatic doRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic tReset();
    logic [31:0] d;
    for (int k = 0; k < N; k++) check("R8 entry reset", ent(k), 64'h1_0000);
    check("R9 no strobe at reset", 64'(tableUpdated), 64'h0);
    doRead(8'h00, d); check("R8 select reset", 64'(d), 64'h0);
    doRead(8'h10, d); check("R8 id reset", 64'(d), 64'h0);
  endtask

  task automatic tSelect();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h0000_00A5, u);
    check("R9 select write no strobe", 64'(u), 64'h0);
    doRead(8'h00, d); check("R2 select readback", 64'(d), 64'hA5);
    doWrite(8'h00, 32'hFFFF_FF3C, u);
    doRead(8'h00, d); check("R2 select upper bits zero", 64'(d), 64'h3C);
  endtask

  task automatic tId();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h0, u);
    doWrite(8'h10, 32'hDE12_3456, u);
    check("R9 id write no strobe", 64'(u), 64'h0);
    doRead(8'h10, d); check("R3 id field", 64'(d), 64'hDE00_0000);
  endtask

  task automatic tVersion();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h1, u);
    doRead(8'h10, d); check("R4 version word", 64'(d), 64'h0017_0011);
    doWrite(8'h10, 32'hFFFF_FFFF, u);
    doRead(8'h10, d); check("R4 version write ignored", 64'(d), 64'h0017_0011);
  endtask

  task automatic tReserved();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h2, u);
    doWrite(8'h10, 32'hFFFF_FFFF, u);
    check("R5 sel2 write no strobe", 64'(u), 64'h0);
    doRead(8'h10, d); check("R5 sel2 reads zero", 64'(d), 64'h0);
    doWrite(8'h00, 32'h5, u);
    doWrite(8'h10, 32'h1234_5678, u);
    doRead(8'h10, d); check("R5 sel5 reads zero", 64'(d), 64'h0);
    check("R5 entry0 untouched", ent(0), 64'h1_0000);
    doWrite(8'h00, 32'h0, u);
    doRead(8'h10, d); check("R5 id untouched", 64'(d), 64'hDE00_0000);
  endtask

  task automatic tEntry();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h10, u);
    doWrite(8'h10, 32'h1234_5678, u);
    check("R9 strobe low half", 64'(u), 64'h1);
    check("R11 entry0 after low write", ent(0), 64'h0000_0000_1234_5678);
    doWrite(8'h00, 32'h11, u);
    doWrite(8'h10, 32'hCAFE_F00D, u);
    check("R9 strobe high half", 64'(u), 64'h1);
    check("R6 entry0 both halves", ent(0), 64'hCAFE_F00D_1234_5678);
    doRead(8'h10, d); check("R6 high half read", 64'(d), 64'hCAFE_F00D);
    doWrite(8'h00, 32'h10, u);
    doRead(8'h10, d); check("R6 low half read", 64'(d), 64'h1234_5678);
    doWrite(8'h00, 32'h3F, u);
    doWrite(8'h10, 32'hAB00_0000, u);
    check("R6 entry23 high write", ent(23), 64'hAB00_0000_0001_0000);
    doWrite(8'h00, 32'h3E, u);
    doWrite(8'h10, 32'h0000_0031, u);
    check("R11 entry23 slice", ent(23), 64'hAB00_0000_0000_0031);
    check("R6 entry22 untouched", ent(22), 64'h1_0000);
    doWrite(8'h00, 32'h13, u);
    doWrite(8'h10, 32'h7700_0000, u);
    check("R6 entry1 high only", ent(1), 64'h7700_0000_0001_0000);
  endtask

  task automatic tRange();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h40, u);
    doWrite(8'h10, 32'hFFFF_FFFF, u);
    check("R7 sel 0x40 no strobe", 64'(u), 64'h0);
    doRead(8'h10, d); check("R7 sel 0x40 reads zero", 64'(d), 64'h0);
    check("R7 entry23 kept", ent(23), 64'hAB00_0000_0000_0031);
    doWrite(8'h00, 32'hFF, u);
    doWrite(8'h10, 32'hFFFF_FFFF, u);
    check("R7 sel 0xFF no strobe", 64'(u), 64'h0);
    doRead(8'h10, d); check("R7 sel 0xFF reads zero", 64'(d), 64'h0);
  endtask

  task automatic tOffsets();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h10, u);
    doWrite(8'h04, 32'h0000_0055, u);
    check("R1 offset 0x04 no strobe", 64'(u), 64'h0);
    doWrite(8'h14, 32'h5555_5555, u);
    doWrite(8'h90, 32'h5555_5555, u);
    check("R1 offset 0x90 no strobe", 64'(u), 64'h0);
    check("R1 entry0 kept", ent(0), 64'hCAFE_F00D_1234_5678);
    doRead(8'h00, d); check("R1 select kept", 64'(d), 64'h10);
    doRead(8'h14, d); check("R1 offset 0x14 reads zero", 64'(d), 64'h0);
    doRead(8'h80, d); check("R1 offset 0x80 reads zero", 64'(d), 64'h0);
  endtask

  task automatic tTiming();
    logic [31:0] d; logic u;
    doWrite(8'h00, 32'h12, u);
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b1; addr = 8'h10; wrData = 32'h0BAD_BEEF;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    check("R10 read sees old state", 64'(rdData), 64'h0001_0000);
    check("R9 strobe on combined cycle", 64'(tableUpdated), 64'h1);
    @(negedge clk);
    check("R9 strobe one cycle", 64'(tableUpdated), 64'h0);
    check("R10 data held", 64'(rdData), 64'h0001_0000);
    doRead(8'h10, d); check("R10 new value next read", 64'(d), 64'h0BAD_BEEF);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSelect();
    tId();
    tVersion();
    tReserved();
    tEntry();
    tRange();
    tOffsets();
    tTiming();
    summary();
  end

endmodule